// File: doc/BRIEF.md
# HDLC Receive Frame Summary Queue

This block sits beside a bit-oriented (HDLC/SDLC) receiver and keeps a short history of finished frames. The receiver's payload bytes go to a separate data FIFO and on to memory by DMA. In parallel, this block counts the payload bytes of the frame in progress. When the frame closes, whether on its closing flag or on an abort, the block pushes one summary entry into a small queue. The entry holds the 14-bit byte count and five receive status bits. The byte counter restarts at once, so a new frame can follow in the very next cycle. The block also sends a one-cycle reset pulse to the CRC checker.

The CPU inspects the summaries later, oldest first, through two read registers. Register A returns the low byte of the count. Register B returns the status bits above the high part of the count, and reading it removes the entry. When more frames complete than the queue can hold, the extra summaries are dropped and a sticky overrun flag is raised. A single enable bit switches the feature on. While that bit is clear, the queue, the counter and the flag are held cleared, and the read registers return zero.

Top module: `frame_summary_queue`

## Requirements
- R1: Entries are read oldest first. With `rdSel`=0 (register A), `rdData` shows count[7:0] of the oldest entry, zero-extended. With `rdSel`=1 (register B), `rdData` shows {status[4:0], count[13:8]}, with the status in bits 10:6.
- R2: An entry's count is the number of cycles with `byteStrobe` high since the previous frame end. This includes a strobe in the frame-end cycle itself. Its status is the `rxStatus` value sampled in the frame-end cycle.
- R3: After a frame end, the counter restarts from zero. A byte strobed in the very next cycle belongs to the new frame.
- R4: A `frameAbort` pulse ends the frame exactly as `frameEnd` does, and pushes its count and status.
- R5: The queue holds DEPTH (10) entries. A frame end that finds the queue full discards the new summary, sets `overrun` on the next cycle, and leaves the stored entries untouched.
- R6: `overrun` stays set until a cycle with `ovrClear` high, or until the enable bit is cleared.
- R7: An entry is removed only by a cycle with `rdStrobe` high and `rdSel`=1. A strobed read of register A removes nothing.
- R8: While the queue is empty, both registers read as zero.
- R9: While `enable` is low, `rdData` is zero and reads remove nothing. Byte strobes and frame ends are ignored. The queue, the counter and `overrun` are cleared.
- R10: Each frame end or abort seen while enabled drives `crcReset` high for exactly the following cycle, even when the summary is dropped for overrun.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Feature enable; low clears all state |
| byteStrobe | input | 1 | One received payload byte this cycle |
| frameEnd | input | 1 | Closing flag of a frame seen this cycle |
| frameAbort | input | 1 | Frame terminated by abort this cycle |
| rxStatus | input | 5 | Receive status bits captured at frame end |
| rdStrobe | input | 1 | CPU read access this cycle |
| rdSel | input | 1 | 0 selects register A, 1 selects register B (pops) |
| ovrClear | input | 1 | Clears the overrun flag |
| rdData | output | 11 | Selected register contents |
| overrun | output | 1 | Sticky summary-queue overrun flag |
| crcReset | output | 1 | One-cycle CRC checker reset after each frame end |

## Verification
The assertions assume that `frameEnd` and `frameAbort` are never high in the same cycle. They also assume that each frame end is a single-cycle pulse, and that `ovrClear` is not raised in a cycle that also overflows the queue. The stimulus keeps to these rules by driving each frame end as one isolated pulse from a task, and by issuing `ovrClear` only while no frame is ending. The expected count, status and flag values are computed from the frame lengths the bench chose.

// File: rtl/fsq_pkg.sv
package fsq_pkg;

  // Strobes issued by the control unit to the datapath each cycle.
  typedef struct packed {
    logic clearAll;   // feature off: flush counter
    logic countByte;  // accept one payload byte
    logic frameDone;  // frame boundary: counter restarts
    logic push;       // write summary into the tail slot
    logic pop;        // retire the head slot
  } fsqStrobes_t;

endpackage

// File: rtl/fsq_ctrl.sv
module fsq_ctrl
  import fsq_pkg::*;
#(
  parameter int DEPTH = 10,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int OCC_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             byteStrobe,
  input  logic             frameEnd,
  input  logic             frameAbort,
  input  logic             rdStrobe,
  input  logic             rdSel,
  input  logic             ovrClear,
  output fsqStrobes_t      stb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic             rdValid,
  output logic             overrun,
  output logic             crcReset
);

  logic [OCC_W-1:0] occupancy;
  logic             frameEvt;
  logic             isFull;
  logic             isEmpty;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  assign frameEvt = enable && (frameEnd || frameAbort);
  assign isFull   = (occupancy == OCC_W'(DEPTH));
  assign isEmpty  = (occupancy == '0);
  assign rdValid  = enable && !isEmpty;

  always_comb begin
    stb           = '0;
    stb.clearAll  = !enable;
    stb.countByte = enable && byteStrobe;
    stb.frameDone = frameEvt;
    stb.push      = frameEvt && !isFull;
    stb.pop       = enable && rdStrobe && rdSel && !isEmpty;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clearAll) begin
      occupancy <= '0;
      wrPtr     <= '0;
      rdPtr     <= '0;
      overrun   <= 1'b0;
      crcReset  <= 1'b0;
    end else begin
      crcReset <= frameEvt;
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
      occupancy <= occupancy + OCC_W'(stb.push) - OCC_W'(stb.pop);
      if (frameEvt && isFull) overrun <= 1'b1;
      else if (ovrClear)      overrun <= 1'b0;
    end
  end

  assert_occupancy_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(DEPTH));

  assert_overrun_on_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (frameEvt && isFull) |=> (overrun && $stable(occupancy) || $past(stb.pop)));

  assert_overrun_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovrClear && enable) |=> overrun);

  assert_disable_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (occupancy == '0 && !overrun && !crcReset));

  assert_pop_needs_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
    stb.pop |-> (rdValid && rdSel));

endmodule

// File: rtl/fsq_data.sv
module fsq_data
  import fsq_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int CNT_W = 14,
  parameter int ST_W  = 5,
  parameter int LO_W  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int ENT_W = CNT_W + ST_W,
  localparam int RD_W  = ENT_W - LO_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fsqStrobes_t      stb,
  input  logic [PTR_W-1:0] wrPtr,
  input  logic [PTR_W-1:0] rdPtr,
  input  logic             rdValid,
  input  logic             rdSel,
  input  logic [ST_W-1:0]  rxStatus,
  output logic [RD_W-1:0]  rdData
);

  logic [CNT_W-1:0] byteCnt;
  logic [CNT_W-1:0] closingCnt;
  logic [ENT_W-1:0] newEntry;
  logic [ENT_W-1:0] slotRd [DEPTH];
  logic [ENT_W-1:0] head;

  assign closingCnt = byteCnt + CNT_W'(stb.countByte);
  assign newEntry   = {rxStatus, closingCnt};

  always_ff @(posedge clk) begin
    if (!rst_n || stb.clearAll || stb.frameDone) byteCnt <= '0;
    else if (stb.countByte)                      byteCnt <= closingCnt;
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [ENT_W-1:0] q;
    always_ff @(posedge clk) begin
      if (stb.push && wrPtr == PTR_W'(g)) q <= newEntry;
    end
    assign slotRd[g] = q;
  end

  assign head = slotRd[rdPtr];

  always_comb begin
    if (!rdValid)   rdData = '0;
    else if (rdSel) rdData = head[ENT_W-1:LO_W];
    else            rdData = RD_W'(head[LO_W-1:0]);
  end

  assert_counter_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stb.frameDone |=> byteCnt == '0);

  assert_empty_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !rdValid |-> rdData == '0);

endmodule

// File: rtl/frame_summary_queue.sv
module frame_summary_queue
  import fsq_pkg::*;
#(
  parameter int DEPTH = 10,
  parameter int CNT_W = 14,
  parameter int ST_W  = 5,
  parameter int LO_W  = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int RD_W  = CNT_W + ST_W - LO_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            enable,
  input  logic            byteStrobe,
  input  logic            frameEnd,
  input  logic            frameAbort,
  input  logic [ST_W-1:0] rxStatus,
  input  logic            rdStrobe,
  input  logic            rdSel,
  input  logic            ovrClear,
  output logic [RD_W-1:0] rdData,
  output logic            overrun,
  output logic            crcReset
);

  fsqStrobes_t      stb;
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic             rdValid;

  fsq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .enable(enable), .byteStrobe(byteStrobe),
    .frameEnd(frameEnd), .frameAbort(frameAbort), .rdStrobe(rdStrobe),
    .rdSel(rdSel), .ovrClear(ovrClear), .stb(stb), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .rdValid(rdValid), .overrun(overrun), .crcReset(crcReset)
  );

  fsq_data #(.DEPTH(DEPTH), .CNT_W(CNT_W), .ST_W(ST_W), .LO_W(LO_W)) i_data (
    .clk(clk), .rst_n(rst_n), .stb(stb), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .rdValid(rdValid), .rdSel(rdSel), .rxStatus(rxStatus), .rdData(rdData)
  );

  assert_single_end_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(frameEnd && frameAbort));

  assert_crc_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (crcReset && !(enable && (frameEnd || frameAbort))) |=> !crcReset);

endmodule

// File: tb/test_frame_summary_queue.sv
module test_frame_summary_queue;

  localparam int DEPTH = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic        byteStrobe = 1'b0;
  logic        frameEnd = 1'b0;
  logic        frameAbort = 1'b0;
  logic [4:0]  rxStatus = '0;
  logic        rdStrobe = 1'b0;
  logic        rdSel = 1'b0;
  logic        ovrClear = 1'b0;
  logic [10:0] rdData;
  logic        overrun;
  logic        crcReset;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  frame_summary_queue i_frame_summary_queue (
    .clk(clk), .rst_n(rst_n), .enable(enable), .byteStrobe(byteStrobe),
    .frameEnd(frameEnd), .frameAbort(frameAbort), .rxStatus(rxStatus),
    .rdStrobe(rdStrobe), .rdSel(rdSel), .ovrClear(ovrClear),
    .rdData(rdData), .overrun(overrun), .crcReset(crcReset)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lenOf(input int k);
    return k * 311 + k * k;
  endfunction

  function automatic int stOf(input int k);
    return (k * 7 + 3) % 32;
  endfunction

  // len strobed bytes, then an end cycle that may carry one more byte.
  task automatic sendFrame(input int len, input int st, input bit abort,
                           input bit endByte, input bit expCrc);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      byteStrobe = 1'b1;
    end
    @(negedge clk);
    byteStrobe = endByte;
    rxStatus   = 5'(st);
    frameEnd   = !abort;
    frameAbort = abort;
    @(negedge clk);
    byteStrobe = 1'b0;
    frameEnd   = 1'b0;
    frameAbort = 1'b0;
    check("R10 crc pulse", int'(crcReset), int'(expCrc));
  endtask

  task automatic readEntry(input int expCnt, input int expSt, input string req);
    @(negedge clk);
    rdStrobe = 1'b1;
    rdSel    = 1'b0;
    #1 check({req, " regA"}, int'(rdData), expCnt % 256);
    rdSel = 1'b1;
    #1 check({req, " regB"}, int'(rdData), expSt * 64 + expCnt / 256);
    @(negedge clk);
    rdStrobe = 1'b0;
    rdSel    = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n  = 1'b1;
    enable = 1'b1;
    @(negedge clk);
    // R8 and R6: reset state
    rdSel = 1'b0;
    #1 check("R8 empty regA", int'(rdData), 0);
    rdSel = 1'b1;
    #1 check("R8 empty regB", int'(rdData), 0);
    check("R6 overrun reset", int'(overrun), 0);

    // Fill the queue; every fourth frame aborted (R4), odd frames add an end-cycle byte (R2)
    for (int k = 0; k < DEPTH; k++)
      sendFrame(lenOf(k), stOf(k), (k % 4) == 3, (k % 2) == 1, 1'b1);
    check("R5 no overrun at full", int'(overrun), 0);
    // Eleventh frame overflows; the crc pulse is still issued (R10)
    sendFrame(5, 9, 1'b0, 1'b0, 1'b1);
    check("R5 overrun set", int'(overrun), 1);
    repeat (20) @(negedge clk);
    check("R6 overrun sticky", int'(overrun), 1);

    // R7: strobed reads of register A do not pop
    for (int r = 0; r < 3; r++) begin
      @(negedge clk);
      rdStrobe = 1'b1;
      rdSel    = 1'b0;
      #1 check("R7 regA no pop", int'(rdData), lenOf(0) % 256);
    end
    @(negedge clk);
    rdStrobe = 1'b0;

    for (int k = 0; k < DEPTH; k++)
      readEntry(lenOf(k) + (k % 2), stOf(k), (k % 4) == 3 ? "R4 abort entry" : "R1 R2 entry");
    readEntry(0, 0, "R5 dropped R8 empty");

    @(negedge clk);
    ovrClear = 1'b1;
    @(negedge clk);
    ovrClear = 1'b0;
    check("R6 overrun cleared", int'(overrun), 0);

    // R3: back-to-back frames, the next begins right after the end cycle
    sendFrame(3, 17, 1'b0, 1'b1, 1'b1);
    sendFrame(4, 30, 1'b1, 1'b0, 1'b1);
    sendFrame(0, 1, 1'b0, 1'b1, 1'b1);
    readEntry(4, 17, "R3 first");
    readEntry(4, 30, "R3 second");
    readEntry(1, 1, "R3 single end byte");

    // R9: overflow, partial frame, then disable
    for (int k = 0; k < DEPTH + 1; k++) sendFrame(1, k, 1'b0, 1'b0, 1'b1);
    check("R5 overrun again", int'(overrun), 1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      byteStrobe = 1'b1;
    end
    @(negedge clk);
    byteStrobe = 1'b0;
    enable     = 1'b0;
    @(negedge clk);
    rdSel = 1'b1;
    #1 check("R9 disabled read", int'(rdData), 0);
    check("R9 overrun cleared", int'(overrun), 0);
    // disabled: strobes, frame end and pop attempts ignored
    sendFrame(7, 3, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rdStrobe = 1'b1;
    #1 check("R9 disabled regB", int'(rdData), 0);
    @(negedge clk);
    rdStrobe = 1'b0;
    enable   = 1'b1;
    @(negedge clk);
    #1 check("R9 queue flushed", int'(rdData), 0);
    sendFrame(2, 12, 1'b0, 1'b0, 1'b1);
    readEntry(2, 12, "R9 counter cleared R2");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule